// File: doc/BRIEF.md
# Interrupt Controller Mode State Machine

This block holds the operating mode of a local interrupt controller and decides which mode changes software may make. Software writes a base control word. Bit 11 of that word enables the controller, and bit 10 selects the extended register-mode. A hardware RESET pulse and an INIT pulse also act on the mode, and each has its own effect. The mode is exposed as the pair {enable, extended}: 2'b00 is globally disabled, 2'b10 is legacy memory-mapped mode, 2'b11 is extended register-mode, and 2'b01 is the illegal combination.

The block emits three kinds of output:
- one-cycle strobes that tell the surrounding register file to clear itself or to rebuild the logical ID;
- a one-cycle fault flag that marks a rejected write;
- two flags that say which access path is live in the current mode.

The block also holds the hardware-loaded controller ID and shows its low byte in the top byte of the legacy ID register view.

Top module: `ctl_mode_fsm`

## Requirements
- R1: While rst_ni is low, and right after it rises, mode_o is 2'b10 (legacy). fault_o, regs_reset_o and ldr_init_o are 0, and id_o is 0.
- R2: A reset_pulse_i moves the controller to legacy from any state and raises regs_reset_o for exactly one cycle. It also loads id_o from hw_id_i, and legacy_id_o then shows id_o[7:0] in bits 31:24 with zeros below. reset_pulse_i wins over init_pulse_i and over a write in the same cycle.
- R3: In legacy mode, a write with bit 11 = 1 and bit 10 = 1 enters extended mode (2'b11). It raises ldr_init_o for one cycle and leaves id_o unchanged.
- R4: A write with bits 11 and 10 both 0, made from legacy or extended mode, enters disabled (2'b00) and raises regs_reset_o for one cycle.
- R5: In extended mode, a write with bit 11 = 1 and bit 10 = 0 is rejected. fault_o is 1 for one cycle and the mode stays extended.
- R6: A write with bit 11 = 0 and bit 10 = 1 is rejected in every state. fault_o pulses and the mode is unchanged.
- R7: In disabled mode, a write with both bits set is rejected with a fault. A write with bit 11 = 1 and bit 10 = 0 enters legacy with no strobe.
- R8: init_pulse_i never changes the mode, never strobes, and blocks any write made in the same cycle. In particular, a controller that is disabled stays disabled.
- R9: reset_pulse_i in disabled mode returns the controller to legacy, raises regs_reset_o, and reloads id_o from hw_id_i.
- R10: mmio_en_o is 1 only in legacy mode, and msr_en_o is 1 only in extended mode. In disabled mode both are 0.
- R11: A write that repeats the current mode changes nothing: no strobe and no fault. Word bits other than 11 and 10 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_we_i | input | 1 | Base control word write strobe |
| base_wdata_i | input | 64 | Base control word; bit 11 enable, bit 10 extended |
| reset_pulse_i | input | 1 | Architectural RESET pulse |
| init_pulse_i | input | 1 | INIT pulse |
| hw_id_i | input | 32 | Hardware-assigned controller ID, loaded on RESET |
| mode_o | output | 2 | Current mode {enable, extended} |
| fault_o | output | 1 | One-cycle flag for a rejected write |
| regs_reset_o | output | 1 | One-cycle register file reset strobe |
| ldr_init_o | output | 1 | One-cycle logical ID initialise strobe |
| mmio_en_o | output | 1 | Memory-mapped access path live |
| msr_en_o | output | 1 | Register-mode access path live |
| id_o | output | 32 | Full controller ID |
| legacy_id_o | output | 32 | Legacy ID register view |

## Verification
The bench walks the legal cycle legacy → extended → disabled → legacy. It also tries every illegal write, so a design that accepted extended→legacy or disabled→extended directly would show the wrong mode_o and no fault. It checks that INIT in the disabled state keeps the controller disabled, and that RESET there restores legacy with a fresh ID; a design that treated INIT like RESET, or kept the old ID, would fail there. It drives RESET and INIT together with a write in the same cycle to catch wrong priority, and it checks that each strobe drops after one cycle, which catches strobes that stick.

// File: rtl/ctl_mode_pkg.sv
package ctl_mode_pkg;
  typedef enum logic [1:0] {
    MODE_DIS = 2'b00,
    MODE_BAD = 2'b01,
    MODE_LEG = 2'b10,
    MODE_EXT = 2'b11
  } mode_e;
endpackage

// File: rtl/ctl_mode_decode.sv
module ctl_mode_decode
  import ctl_mode_pkg::*;
#(
  parameter int BASE_W  = 64,
  parameter int EN_BIT  = 11,
  parameter int EXT_BIT = 10
) (
  input  mode_e             cur_i,
  input  logic [BASE_W-1:0] wdata_i,
  output mode_e             nxt_o,
  output logic              illegal_o
);
  mode_e req;

  always_comb begin
    req       = mode_e'({wdata_i[EN_BIT], wdata_i[EXT_BIT]});
    illegal_o = (req == MODE_BAD)
             || (cur_i == MODE_EXT && req == MODE_LEG)
             || (cur_i == MODE_DIS && req == MODE_EXT);
    nxt_o     = illegal_o ? cur_i : req;
  end
endmodule

// File: rtl/ctl_mode_id.sv
module ctl_mode_id #(
  parameter int ID_W      = 32,
  parameter int LEG_ID_W  = 8,
  parameter int LEG_REG_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [ID_W-1:0]      hw_id_i,
  output logic [ID_W-1:0]      id_o,
  output logic [LEG_REG_W-1:0] legacy_id_o
);
  localparam int PAD_W = LEG_REG_W - LEG_ID_W;

  logic [ID_W-1:0] id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     id_q <= '0;
    else if (load_i) id_q <= hw_id_i;
  end

  assign id_o        = id_q;
  assign legacy_id_o = {id_q[LEG_ID_W-1:0], {PAD_W{1'b0}}};

  AST_ID_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(id_q)); // R3
  AST_ID_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> id_q == $past(hw_id_i)); // R2
endmodule

// File: rtl/ctl_mode_fsm.sv
module ctl_mode_fsm
  import ctl_mode_pkg::*;
#(
  parameter int BASE_W    = 64,
  parameter int EN_BIT    = 11,
  parameter int EXT_BIT   = 10,
  parameter int ID_W      = 32,
  parameter int LEG_ID_W  = 8,
  parameter int LEG_REG_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 base_we_i,
  input  logic [BASE_W-1:0]    base_wdata_i,
  input  logic                 reset_pulse_i,
  input  logic                 init_pulse_i,
  input  logic [ID_W-1:0]      hw_id_i,
  output logic [1:0]           mode_o,
  output logic                 fault_o,
  output logic                 regs_reset_o,
  output logic                 ldr_init_o,
  output logic                 mmio_en_o,
  output logic                 msr_en_o,
  output logic [ID_W-1:0]      id_o,
  output logic [LEG_REG_W-1:0] legacy_id_o
);
  mode_e mode_q, mode_d, dec_nxt;
  logic  dec_illegal;
  logic  fault_d, regs_rst_d, ldr_d, id_load;

  ctl_mode_decode #(
    .BASE_W (BASE_W),
    .EN_BIT (EN_BIT),
    .EXT_BIT(EXT_BIT)
  ) u_dec (
    .cur_i    (mode_q),
    .wdata_i  (base_wdata_i),
    .nxt_o    (dec_nxt),
    .illegal_o(dec_illegal)
  );

  // priority: RESET, then INIT (blocks writes), then software write
  always_comb begin
    mode_d     = mode_q;
    fault_d    = 1'b0;
    regs_rst_d = 1'b0;
    ldr_d      = 1'b0;
    id_load    = 1'b0;
    if (reset_pulse_i) begin
      mode_d     = MODE_LEG;
      regs_rst_d = 1'b1;
      id_load    = 1'b1;
    end else if (init_pulse_i) begin
      mode_d = mode_q;
    end else if (base_we_i) begin
      fault_d    = dec_illegal;
      mode_d     = dec_nxt;
      regs_rst_d = (dec_nxt == MODE_DIS) && (mode_q != MODE_DIS);
      ldr_d      = (dec_nxt == MODE_EXT) && (mode_q == MODE_LEG);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q       <= MODE_LEG;
      fault_o      <= 1'b0;
      regs_reset_o <= 1'b0;
      ldr_init_o   <= 1'b0;
    end else begin
      mode_q       <= mode_d;
      fault_o      <= fault_d;
      regs_reset_o <= regs_rst_d;
      ldr_init_o   <= ldr_d;
    end
  end

  ctl_mode_id #(
    .ID_W     (ID_W),
    .LEG_ID_W (LEG_ID_W),
    .LEG_REG_W(LEG_REG_W)
  ) u_id (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (id_load),
    .hw_id_i    (hw_id_i),
    .id_o       (id_o),
    .legacy_id_o(legacy_id_o)
  );

  assign mode_o    = mode_q;
  assign mmio_en_o = (mode_q == MODE_LEG);
  assign msr_en_o  = (mode_q == MODE_EXT);

  AST_NEVER_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != MODE_BAD); // R6
  AST_FAULT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> $stable(mode_o)); // R5
  AST_NO_EXT_TO_LEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_EXT && !reset_pulse_i) |=> mode_q != MODE_LEG); // R5
  AST_RESET_LEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_pulse_i |=> (mode_q == MODE_LEG) && regs_reset_o); // R2
  AST_INIT_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (init_pulse_i && !reset_pulse_i) |=> $stable(mode_q) && !regs_reset_o); // R8
  AST_LDR_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ldr_init_o |-> mode_q == MODE_EXT && $past(mode_q) == MODE_LEG); // R3
  AST_PATH_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mmio_en_o && msr_en_o)); // R10
endmodule

// File: tb/tb_ctl_mode_fsm.sv
module tb_ctl_mode_fsm;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        we, rp, ip;
  logic [63:0] wd;
  logic [31:0] hw_id;
  logic [1:0]  mode;
  logic        fault, regs_rst, ldr, mmio_en, msr_en;
  logic [31:0] id, leg_id;
  int          checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_mode_fsm dut (
    .clk_i(clk), .rst_ni(rst_n), .base_we_i(we), .base_wdata_i(wd),
    .reset_pulse_i(rp), .init_pulse_i(ip), .hw_id_i(hw_id),
    .mode_o(mode), .fault_o(fault), .regs_reset_o(regs_rst), .ldr_init_o(ldr),
    .mmio_en_o(mmio_en), .msr_en_o(msr_en), .id_o(id), .legacy_id_o(leg_id)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // apply one cycle of stimulus; outputs are checked 1 time unit after the edge
  task automatic step(input logic w, input logic [63:0] d, input logic r, input logic i);
    @(negedge clk);
    we = w; wd = d; rp = r; ip = i;
    @(posedge clk);
    #1;
    we = 0; rp = 0; ip = 0; wd = '0;
  endtask

  task automatic expect_out(input string tag, input logic [1:0] m, input logic f,
                            input logic rr, input logic li);
    chk({tag, " mode"}, mode, m);
    chk({tag, " fault"}, fault, f);
    chk({tag, " regs_reset"}, regs_rst, rr);
    chk({tag, " ldr_init"}, ldr, li);
  endtask

  task automatic t_reset_state();
    expect_out("R1", 2'b10, 0, 0, 0);
    chk("R1 id", id, 0);
  endtask

  task automatic t_reset_pulse();
    hw_id = 32'hA1B2C3D4;
    step(0, 0, 1, 0);
    expect_out("R2", 2'b10, 0, 1, 0);
    chk("R2 id", id, 32'hA1B2C3D4);
    chk("R2 legacy view", leg_id, 32'hD400_0000);
    step(0, 0, 0, 0);
    chk("R2 strobe one cycle", regs_rst, 0);
    chk("R10 legacy mmio", mmio_en, 1);
    chk("R10 legacy msr", msr_en, 0);
  endtask

  task automatic t_leg_to_ext();
    step(1, 64'hFFFF_0000_0000_0CFF, 0, 0);
    expect_out("R3", 2'b11, 0, 0, 1);
    chk("R3 id kept", id, 32'hA1B2C3D4);
    step(0, 0, 0, 0);
    chk("R3 strobe one cycle", ldr, 0);
    chk("R10 ext msr", msr_en, 1);
    chk("R10 ext mmio", mmio_en, 0);
  endtask

  task automatic t_same_mode();
    step(1, 64'h0000_0000_0000_3C00, 0, 0);
    expect_out("R11", 2'b11, 0, 0, 0);
  endtask

  task automatic t_ext_to_leg();
    step(1, 64'h800, 0, 0);
    expect_out("R5", 2'b11, 1, 0, 0);
    step(0, 0, 0, 0);
    chk("R5 fault one cycle", fault, 0);
  endtask

  task automatic t_bad_combo(input logic [1:0] m);
    step(1, 64'h400, 0, 0);
    expect_out("R6", m, 1, 0, 0);
  endtask

  task automatic t_init_with_write(input logic [1:0] m);
    step(1, 64'h0, 0, 1);
    expect_out("R8", m, 0, 0, 0);
  endtask

  task automatic t_to_dis(input string tag);
    step(1, 64'h0, 0, 0);
    expect_out(tag, 2'b00, 0, 1, 0);
    chk("R10 dis mmio", mmio_en, 0);
    chk("R10 dis msr", msr_en, 0);
  endtask

  task automatic t_dis_direct_ext();
    step(1, 64'hC00, 0, 0);
    expect_out("R7 direct ext", 2'b00, 1, 0, 0);
  endtask

  task automatic t_dis_to_leg();
    step(1, 64'h800, 0, 0);
    expect_out("R7 to legacy", 2'b10, 0, 0, 0);
  endtask

  task automatic t_reset_in_dis();
    hw_id = 32'h1234_5678;
    step(0, 0, 1, 0);
    expect_out("R9", 2'b10, 0, 1, 0);
    chk("R9 id", id, 32'h1234_5678);
    chk("R9 legacy view", leg_id, 32'h7800_0000);
  endtask

  task automatic t_reset_priority();
    step(1, 64'h0, 1, 1);
    expect_out("R2 priority", 2'b10, 0, 1, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; we = 0; rp = 0; ip = 0; wd = '0; hw_id = '0;
    #(CLK_PERIOD * 3);
    #1;
    t_reset_state();
    @(negedge clk);
    rst_n = 1;
    @(posedge clk);
    #1;
    t_reset_state();
    t_reset_pulse();
    t_leg_to_ext();
    t_same_mode();
    t_ext_to_leg();
    t_bad_combo(2'b11);
    t_init_with_write(2'b11);
    t_to_dis("R4 from ext");
    t_dis_direct_ext();
    t_bad_combo(2'b00);
    t_init_with_write(2'b00);
    t_reset_in_dis();
    t_to_dis("R4 from legacy");
    t_dis_to_leg();
    t_reset_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule